// File: doc/BRIEF.md
# PCM highway time-slot interleaver

This block moves a 125 µs PCM frame of 32 eight-bit slots between a byte-wide user interface and a serial system highway. The highway may run at 1, 2, 4 or 8 times the 2.048 Mbit/s base data rate. When it runs faster, the slot positions on the wire are grouped in runs of one, two, four or eight. Only the position picked by a static phase setting carries a real slot. The other positions are holes: transmit is disabled and idles high, and anything received there is dropped.

The highway clock, the frame sync and the receive line all arrive asynchronously. They are brought into the system clock domain and the highway clock edges are detected there. One edge drives transmit data and the other samples receive data, and a static option picks which is which. The highway clock may also run 1, 2, 4 or 8 times faster than the data rate. Each bit then lasts that many clock periods and is sampled in the middle one. The user supplies transmit bytes when asked, one slot ahead of their use, and receives completed bytes with their slot number.

Top module: `pcm_ilv_top`

## Requirements
- R1: After reset, and until the first frame sync is accepted, txOe is 0, txd is 1, and rxValid and txReq stay 0.
- R2: cfgRateLog n (0..3) sets a group of 2^n byte positions per slot. Of each group, only position cfgPhase carries data with txOe 1. Every other position has txOe 0 and txd 1.
- R3: A frame sync sampled high marks the next highway bit period as bit 0 of position 0. Slot k occupies group k, and each byte leaves MSB first.
- R4: cfgClkLog m (0..3) stretches each bit to 2^m highway clock cycles. Receive data is sampled in cycle index 2^m/2 of the bit (index 0 when m is 0).
- R5: cfgTxFall 0 drives data on the highway clock rising edge and samples on the falling edge. cfgTxFall 1 swaps the two edges.
- R6: Each received real slot produces one single-cycle rxValid pulse, with the byte MSB-first in rxByte and its number in rxSlot. Hole positions produce no pulse.
- R7: txReq pulses with txReqSlot. txData is captured in the system clock cycle where txReq is high. Slot k+1 (mod 32) is requested when slot k starts, and slot 0 is also requested when a frame sync is sampled.
- R8: If cfgPhase >= 2^cfgRateLog, or cfgRateLog+cfgClkLog > 3, cfgErr is 1. The block is then idle: txOe 0, txd 1, no rxValid, no txReq. After the setting is corrected, it stays idle until a new frame sync.
- R9: Without a new frame sync, the position count wraps after the last bit of slot 31 and the next frame follows with the same alignment. A sync in the last bit period of a frame keeps that alignment.
- R10: Each highway clock level must last at least two system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hwClk | input | 1 | Highway bit clock (asynchronous) |
| frameSync | input | 1 | Frame sync, high for one highway bit period before bit 0 |
| rxd | input | 1 | Highway serial receive data |
| cfgRateLog | input | 2 | log2 of the rate multiplier |
| cfgClkLog | input | 2 | log2 of highway clocks per data bit |
| cfgPhase | input | 3 | Position of the real slot within its group |
| cfgTxFall | input | 1 | 1: drive on falling edge, sample on rising edge |
| txData | input | 8 | Byte for the slot named by txReqSlot |
| txReq | output | 1 | Transmit byte request strobe |
| txReqSlot | output | 5 | Slot whose byte is requested |
| rxValid | output | 1 | Received byte strobe |
| rxByte | output | 8 | Received byte |
| rxSlot | output | 5 | Slot number of rxByte |
| txd | output | 1 | Highway serial transmit data |
| txOe | output | 1 | Transmit output enable |
| cfgErr | output | 1 | Invalid configuration flag |

## Verification
A highway clock edge reaches txd and txOe after the two-stage synchronizer, the edge detector and one output register. That is at most four system clock cycles. The bench therefore compares the transmit pins in the last system cycle before the next drive edge, with each level held four system cycles. A received byte shows up on rxValid about four system cycles after the sample edge of its last bit. The bench collects these pulses in a monitor and judges them a few cycles after each frame ends. cfgErr follows a configuration change one system cycle later, and the bench waits two cycles before reading it.

// File: rtl/pcm_ilv_pkg.sv
package pcm_ilv_pkg;
  // Strobes handed from the control to the datapath, one system cycle wide.
  typedef struct packed {
    logic drive;      // a drive edge occurred this cycle
    logic oeNext;     // output enable for the period now starting
    logic loadTx;     // first bit of a real slot: load shifter
    logic shiftTx;    // later bit of a real slot: advance shifter
    logic sampleBit;  // sample rxd now
    logic lastBit;    // the sampled bit is the last of its byte
    logic kill;       // configuration invalid: force idle
  } ilvStrobes_t;
endpackage

// File: rtl/pcm_ilv_sync.sv
module pcm_ilv_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/pcm_ilv_ctrl.sv
module pcm_ilv_ctrl
  import pcm_ilv_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int BITS    = 8,
  parameter int MAX_LOG = 3,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(BITS),
  localparam int LOG_W  = $clog2(MAX_LOG + 1),
  localparam int CNT_W  = SLOT_W + BIT_W + MAX_LOG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hwClkS,
  input  logic              fsS,
  input  logic [LOG_W-1:0]  cfgRateLog,
  input  logic [LOG_W-1:0]  cfgClkLog,
  input  logic [MAX_LOG-1:0] cfgPhase,
  input  logic              cfgTxFall,
  output ilvStrobes_t       stb,
  output logic [SLOT_W-1:0] rxSlotIdx,
  output logic              reqStb,
  output logic [SLOT_W-1:0] reqSlot,
  output logic              cfgErr
);
  typedef struct packed {
    logic              used;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitIdx;
  } posInfo_t;

  logic             hwQ;
  logic             riseEdge, fallEdge, driveEdge, sampleEdge;
  logic [CNT_W-1:0] cnt, cntNext, frameLast;
  logic             active, activeNext, fsSeen;
  logic             errQ, errNow;
  posInfo_t         dNext, dCur;
  logic             bitStartNext, midCur;

  // Where a count falls in the frame: position, slot, bit.
  function automatic posInfo_t decodePos(input logic [CNT_W-1:0] c);
    posInfo_t         d;
    logic [CNT_W-1:0] bitPos;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] grpMask;
    bitPos  = c >> cfgClkLog;
    pos     = bitPos >> BIT_W;
    grpMask = (CNT_W'(1) << cfgRateLog) - CNT_W'(1);
    d.used   = ((pos & grpMask) == CNT_W'(cfgPhase));
    d.slot   = SLOT_W'(pos >> cfgRateLog);
    d.bitIdx = bitPos[BIT_W-1:0];
    return d;
  endfunction

  // Clock cycle within the current data bit.
  function automatic logic [CNT_W-1:0] cycOf(input logic [CNT_W-1:0] c);
    return c & ((CNT_W'(1) << cfgClkLog) - CNT_W'(1));
  endfunction

  assign riseEdge   = hwClkS & ~hwQ;
  assign fallEdge   = ~hwClkS & hwQ;
  assign driveEdge  = cfgTxFall ? fallEdge : riseEdge;
  assign sampleEdge = cfgTxFall ? riseEdge : fallEdge;

  assign errNow = (int'(cfgPhase) >= (1 << cfgRateLog)) ||
                  ((int'(cfgRateLog) + int'(cfgClkLog)) > MAX_LOG);
  assign frameLast = CNT_W'(((SLOTS * BITS) << (int'(cfgRateLog) + int'(cfgClkLog))) - 1);

  assign cntNext    = fsSeen ? '0 : ((cnt == frameLast) ? '0 : cnt + CNT_W'(1));
  assign activeNext = fsSeen | active;

  assign dNext        = decodePos(cntNext);
  assign dCur         = decodePos(cnt);
  assign bitStartNext = (cycOf(cntNext) == '0);
  assign midCur       = (cycOf(cnt) == ((CNT_W'(1) << cfgClkLog) >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hwQ    <= 1'b0;
      cnt    <= '0;
      active <= 1'b0;
      fsSeen <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      hwQ  <= hwClkS;
      errQ <= errNow;
      if (errQ) begin
        active <= 1'b0;
        fsSeen <= 1'b0;
      end else if (driveEdge) begin
        cnt    <= cntNext;
        active <= activeNext;
        fsSeen <= 1'b0;
      end else if (sampleEdge && fsS) begin
        fsSeen <= 1'b1;
      end
    end
  end

  logic goDrive;
  assign goDrive = driveEdge & activeNext & ~errQ;

  always_comb begin
    stb.drive     = driveEdge;
    stb.oeNext    = goDrive & dNext.used;
    stb.loadTx    = goDrive & dNext.used & bitStartNext & (dNext.bitIdx == '0);
    stb.shiftTx   = goDrive & dNext.used & bitStartNext & (dNext.bitIdx != '0);
    stb.sampleBit = sampleEdge & active & ~errQ & dCur.used & midCur;
    stb.lastBit   = (dCur.bitIdx == BIT_W'(BITS - 1));
    stb.kill      = errQ;
  end

  assign rxSlotIdx = dCur.slot;
  assign reqStb    = stb.loadTx | (sampleEdge & fsS & ~errQ);
  assign reqSlot   = stb.loadTx ? dNext.slot + SLOT_W'(1) : '0;
  assign cfgErr    = errQ;
endmodule

// File: rtl/pcm_ilv_dp.sv
module pcm_ilv_dp
  import pcm_ilv_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ilvStrobes_t       stb,
  input  logic [SLOT_W-1:0] rxSlotIdx,
  input  logic              reqStb,
  input  logic              rxS,
  input  logic [BITS-1:0]   txData,
  output logic              txd,
  output logic              txOe,
  output logic              rxValid,
  output logic [BITS-1:0]   rxByte,
  output logic [SLOT_W-1:0] rxSlot
);
  logic [BITS-1:0] txSh, txNext, rxSh;
  logic            txOeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      txSh    <= '0;
      txNext  <= '0;
      txOeQ   <= 1'b0;
      rxSh    <= '0;
      rxValid <= 1'b0;
      rxByte  <= '0;
      rxSlot  <= '0;
    end else begin
      if (stb.kill)       txOeQ <= 1'b0;
      else if (stb.drive) txOeQ <= stb.oeNext;

      if (stb.loadTx)       txSh <= txNext;
      else if (stb.shiftTx) txSh <= txSh << 1;

      if (reqStb) txNext <= txData;

      rxValid <= 1'b0;
      if (stb.sampleBit) begin
        rxSh <= {rxSh[BITS-2:0], rxS};
        if (stb.lastBit) begin
          rxValid <= 1'b1;
          rxByte  <= {rxSh[BITS-2:0], rxS};
          rxSlot  <= rxSlotIdx;
        end
      end
    end
  end

  assign txOe = txOeQ;
  assign txd  = txOeQ ? txSh[BITS-1] : 1'b1;
endmodule

// File: rtl/pcm_ilv_top.sv
module pcm_ilv_top
  import pcm_ilv_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int BITS    = 8,
  parameter int MAX_LOG = 3,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hwClk,
  input  logic               frameSync,
  input  logic               rxd,
  input  logic [LOG_W-1:0]   cfgRateLog,
  input  logic [LOG_W-1:0]   cfgClkLog,
  input  logic [MAX_LOG-1:0] cfgPhase,
  input  logic               cfgTxFall,
  input  logic [BITS-1:0]    txData,
  output logic               txReq,
  output logic [SLOT_W-1:0]  txReqSlot,
  output logic               rxValid,
  output logic [BITS-1:0]    rxByte,
  output logic [SLOT_W-1:0]  rxSlot,
  output logic               txd,
  output logic               txOe,
  output logic               cfgErr
);
  logic [2:0]        syncOut;
  ilvStrobes_t       stb;
  logic [SLOT_W-1:0] rxSlotIdx;

  pcm_ilv_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({hwClk, frameSync, rxd}),
    .dout(syncOut)
  );

  pcm_ilv_ctrl #(.SLOTS(SLOTS), .BITS(BITS), .MAX_LOG(MAX_LOG)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hwClkS    (syncOut[2]),
    .fsS       (syncOut[1]),
    .cfgRateLog(cfgRateLog),
    .cfgClkLog (cfgClkLog),
    .cfgPhase  (cfgPhase),
    .cfgTxFall (cfgTxFall),
    .stb       (stb),
    .rxSlotIdx (rxSlotIdx),
    .reqStb    (txReq),
    .reqSlot   (txReqSlot),
    .cfgErr    (cfgErr)
  );

  pcm_ilv_dp #(.SLOTS(SLOTS), .BITS(BITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .rxSlotIdx(rxSlotIdx),
    .reqStb   (txReq),
    .rxS      (syncOut[0]),
    .txData   (txData),
    .txd      (txd),
    .txOe     (txOe),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .rxSlot   (rxSlot)
  );
endmodule

// File: rtl/pcm_ilv_chk.sv
module pcm_ilv_chk (
  input logic clk,
  input logic rst,
  input logic txOe,
  input logic rxValid,
  input logic txReq,
  input logic cfgErr
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!txOe && !rxValid && !txReq));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cfgErr |=> (!txOe && !rxValid));

  p_err_noreq_r8: assert property (@(posedge clk) disable iff (rst)
    cfgErr |-> !txReq);

  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  // R10 spacing of highway edges keeps requests one cycle wide
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    txReq |=> !txReq);
endmodule

bind pcm_ilv_top pcm_ilv_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .txOe   (txOe),
  .rxValid(rxValid),
  .txReq  (txReq),
  .cfgErr (cfgErr)
);

// File: tb/tb_pcm_ilv_top.sv
module tb_pcm_ilv_top;
  localparam int H = 4;  // system cycles per highway clock level

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, hwClk = 1'b0, frameSync = 1'b0, rxd = 1'b0;
  logic [1:0] cfgRateLog = '0, cfgClkLog = '0;
  logic [2:0] cfgPhase = '0;
  logic       cfgTxFall = 1'b0;
  logic [7:0] txData;
  logic       txReq, rxValid, txd, txOe, cfgErr;
  logic [4:0] txReqSlot, rxSlot;
  logic [7:0] rxByte;

  logic [7:0] txMem [32];
  logic [7:0] rxMem [32];
  logic [7:0] rxGot [32];

  assign txData = txMem[txReqSlot];

  pcm_ilv_top dut (
    .clk(clk), .rst(rst), .hwClk(hwClk), .frameSync(frameSync), .rxd(rxd),
    .cfgRateLog(cfgRateLog), .cfgClkLog(cfgClkLog), .cfgPhase(cfgPhase),
    .cfgTxFall(cfgTxFall), .txData(txData), .txReq(txReq), .txReqSlot(txReqSlot),
    .rxValid(rxValid), .rxByte(rxByte), .rxSlot(rxSlot), .txd(txd), .txOe(txOe),
    .cfgErr(cfgErr)
  );

  int nChk = 0, nBad = 0;
  int lm = 0, ld = 0, ph = 0;
  logic driveLvl = 1'b1;
  int rxCnt = 0, reqCnt = 0, reqBad = 0, lastReq = 31;
  int txBad = 0, badCyc = 0, badAct = 0, badExp = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rxValid) begin
      rxCnt++;
      rxGot[rxSlot] = rxByte;
    end
    if (txReq) begin
      reqCnt++;
      if (!(txReqSlot == 5'd0 || int'(txReqSlot) == (lastReq + 1) % 32)) reqBad++;
      lastReq = int'(txReqSlot);
    end
  end

  // One highway bit period: drive edge, sample edge, compare before next drive edge.
  task automatic doCycle(input logic fsv, input logic rxv, input logic eOe,
                         input logic eD, input int c);
    @(negedge clk);
    hwClk = driveLvl; frameSync = fsv; rxd = rxv;
    repeat (H) @(negedge clk);
    hwClk = ~driveLvl;
    repeat (H - 1) @(negedge clk);
    if (txOe !== eOe || txd !== eD) begin
      if (txBad == 0) begin
        badCyc = c; badAct = {txOe, txd}; badExp = {eOe, eD};
      end
      txBad++;
    end
  endtask

  task automatic startCfg(input int rl, input int cl, input int p, input bit fall);
    rst = 1'b1;
    lm = rl; ld = cl; ph = p;
    cfgRateLog = 2'(rl); cfgClkLog = 2'(cl); cfgPhase = 3'(p); cfgTxFall = fall;
    driveLvl = fall ? 1'b0 : 1'b1;
    hwClk = ~driveLvl; frameSync = 1'b0;
    for (int i = 0; i < 32; i++) txMem[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idleCycles(input int n, input string req);
    txBad = 0;
    for (int i = 0; i < n; i++) doCycle(1'b0, 1'($urandom), 1'b0, 1'b1, -1);
    check(txBad == 0, req, "idle txOe/txd", badAct, badExp);
  endtask

  task automatic syncCycle(input string req);
    txBad = 0;
    reqCnt = 0;
    lastReq = 31;
    doCycle(1'b1, 1'($urandom), 1'b0, 1'b1, -1);
    check(txBad == 0, req, "idle during sync period", badAct, badExp);
  endtask

  task automatic runFrame(input string req, input bit fsEnd);
    int len, bitPos, pos, bIdx, cyc, mid;
    logic eOe, eD, rxv, b;
    len = 256 << (lm + ld);
    mid = (1 << ld) >> 1;
    for (int i = 0; i < 32; i++) begin
      rxMem[i] = 8'($urandom);
      rxGot[i] = ~rxMem[i];
    end
    rxCnt = 0; txBad = 0; reqBad = 0;
    for (int c = 0; c < len; c++) begin
      bitPos = c >> ld;
      cyc    = c % (1 << ld);
      pos    = bitPos >> 3;
      bIdx   = bitPos % 8;
      if ((pos % (1 << lm)) == ph) begin
        eOe = 1'b1;
        eD  = txMem[pos >> lm][7 - bIdx];
        b   = rxMem[pos >> lm][7 - bIdx];
        rxv = (cyc == mid) ? b : ~b;
      end else begin
        eOe = 1'b0; eD = 1'b1; rxv = 1'($urandom);
      end
      doCycle(fsEnd && (c == len - 1), rxv, eOe, eD, c);
    end
    repeat (8) @(negedge clk);
    check(txBad == 0, req, $sformatf("R3 tx pattern first bad cycle %0d {oe,d}", badCyc),
          badAct, badExp);
    check(rxCnt == 32, "R6", "rx strobes per frame", rxCnt, 32);
    begin
      int nm = 0, first = -1;
      for (int i = 0; i < 32; i++)
        if (rxGot[i] !== rxMem[i]) begin nm++; if (first < 0) first = i; end
      check(nm == 0, "R4", $sformatf("rx bytes (mid-bit sampling), first bad slot %0d", first),
            nm, 0);
    end
    check(reqBad == 0, "R7", "tx request slot order", reqBad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    // Reset state
    startCfg(0, 0, 0, 1'b0);
    check(txOe === 1'b0 && txd === 1'b1, "R1", "reset txOe/txd", {txOe, txd}, 2'b01);
    check(rxValid === 1'b0 && txReq === 1'b0 && cfgErr === 1'b0, "R1", "reset strobes",
          {rxValid, txReq, cfgErr}, 0);
    idleCycles(6, "R1");

    // Base rate, two frames
    syncCycle("R1");
    runFrame("R3 base rate", 1'b1);
    runFrame("R9 back-to-back", 1'b1);

    // x4, phase 2: frame wrap without sync then with sync
    startCfg(2, 0, 2, 1'b0);
    syncCycle("R2");
    runFrame("R2 x4 phase 2", 1'b0);
    runFrame("R9 wrap without sync", 1'b1);

    // x4, phase 1, falling-edge transmit
    startCfg(2, 0, 1, 1'b1);
    idleCycles(4, "R5");
    syncCycle("R5");
    runFrame("R5 falling drive", 1'b1);

    // x2 phase 1 with two clocks per bit
    startCfg(1, 1, 1, 1'b0);
    syncCycle("R4");
    runFrame("R4 clk ratio 2", 1'b1);

    // base rate, four clocks per bit, falling edge
    startCfg(0, 2, 0, 1'b1);
    syncCycle("R4");
    runFrame("R4 clk ratio 4", 1'b1);

    // x8, last phase
    startCfg(3, 0, 7, 1'b0);
    syncCycle("R2");
    runFrame("R2 x8 phase 7", 1'b1);

    // Invalid phase, then corrected
    startCfg(1, 0, 3, 1'b0);
    check(cfgErr === 1'b1, "R8", "cfgErr for phase >= multiplier", cfgErr, 1);
    rxCnt = 0;
    syncCycle("R8");
    idleCycles(300, "R8");
    check(rxCnt == 0 && reqCnt == 0, "R8", "no strobes while invalid", rxCnt + reqCnt, 0);
    cfgPhase = 3'd1; ph = 1;
    repeat (2) @(negedge clk);
    check(cfgErr === 1'b0, "R8", "cfgErr cleared after fix", cfgErr, 0);
    idleCycles(40, "R8");
    syncCycle("R8");
    runFrame("R8 resume after sync", 1'b1);

    // Invalid combined scaling
    startCfg(2, 2, 0, 1'b0);
    check(cfgErr === 1'b1, "R8", "cfgErr for rate+clk log > 3", cfgErr, 1);
    idleCycles(20, "R8");

    // Random valid configurations
    for (int k = 0; k < 2; k++) begin
      int rl, cl, p;
      bit f;
      rl = int'($urandom % 4);
      cl = int'($urandom % (4 - rl));
      p  = int'($urandom % (1 << rl));
      f  = 1'($urandom);
      startCfg(rl, cl, p, f);
      syncCycle("R2");
      runFrame($sformatf("R2 random rate %0d clk %0d phase %0d", rl, cl, p), 1'b1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule